// File: doc/BRIEF.md
# Adaptive-Window Impulse Noise Filter

This block cleans salt-and-pepper impulse noise from an 8-bit grayscale pixel stream. Pixels enter in raster order over a valid/ready handshake. Eight rows of storage keep the neighbourhood of the pixel being worked on. The image dimensions are compile-time parameters. Edge rows and columns are handled by replicating the nearest valid pixel. A replicated position counts exactly like a real one.

Only a pixel that sits at an impulse extreme is treated as damaged. Every other pixel leaves the block unchanged. For a damaged pixel the decision starts from a 3×3 neighbourhood. If more than half of that neighbourhood is itself damaged, the neighbourhood widens to 5×5, and then to 7×7. The first size that passes supplies a rank-order median taken over its undamaged members only. When even 7×7 fails, the pixel takes the value of the last pixel the block sent out.

Every pixel costs the same fixed number of engine cycles once its neighbourhood has arrived. Output order is input order. The block resets its internal state after the last pixel of a frame leaves, and the next frame can then start.

Top module: `impulse_adapt_filter`

## Requirements
- R1: A pixel whose value lies in 1..254 is emitted with exactly its input value.
- R2: A pixel is classed as damaged exactly when its value is 0 or 255; the values 1 and 254 are undamaged.
- R3: A damaged pixel first looks at its 3×3 neighbourhood. If at most 4 of those 9 positions are damaged, its output is the median of the undamaged values in that 3×3 neighbourhood.
- R4: If the 3×3 neighbourhood holds 5 or more damaged positions and the 5×5 neighbourhood holds at most 12, the output is the median of the undamaged values in the 5×5 neighbourhood.
- R5: If the 5×5 neighbourhood holds 13 or more damaged positions and the 7×7 neighbourhood holds at most 24, the output is the median of the undamaged values in the 7×7 neighbourhood.
- R6: If the 7×7 neighbourhood holds 25 or more damaged positions, the output equals the previously emitted pixel.
- R7: The median is taken over undamaged values only. For an even count of undamaged values it is the lower of the two middle values, that is the ceil(n/2)-th smallest.
- R8: Neighbourhood positions outside the image take the value of the nearest in-image pixel (row and column clamped independently). They are counted as positions both for damage counts and for the median.
- R9: The previously emitted value is 128 at the first pixel of each frame, both after reset and after the last pixel of the previous frame has left.
- R10: Exactly IMG_W×IMG_H outputs leave per frame, in input raster order. While out_valid is high and out_ready is low, out_valid and out_data hold their values.
- R11: During and just after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts an input pixel this cycle |
| in_data | input | 8 | Input pixel, raster order |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | 8 | Filtered pixel, raster order |

## Verification
The assertions check the following on every cycle:
- The held-output rule under back-pressure.
- That a passed-through or median-restored pixel is never an impulse value.
- That the median rank is inside the count of undamaged positions.
- That the previous-value register returns to 128 after a frame ends.

Whether the correct window size was chosen, whether the median is the lower-middle value, how edges are replicated, and whether the value carried across frames is right depend on whole neighbourhoods. Only the bench's scenarios can show those. The bench therefore runs frames ranging from noise-free to fully corrupted corners, with gaps on the input and stalls on the output. It compares every pixel against an arithmetic model.

// File: rtl/ifilt_pkg.sv
package ifilt_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SPAN   = 7;
    localparam int RADIUS = 3;
    localparam int TAPS   = SPAN * SPAN;
    localparam int CENTER = TAPS / 2;
    localparam int RANKW  = $clog2(TAPS + 1);

    typedef logic [7:0] pix_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PREP,
        ST_SEARCH,
        ST_EMIT
    } eng_st_e;

    typedef enum logic [1:0] {
        RES_KEEP,
        RES_MEDIAN,
        RES_PREV
    } res_kind_e;

    function automatic logic is_impulse(input pix_t v);
        return (v == 8'h00) || (v == 8'hFF);
    endfunction

    // Chebyshev distance of a tap from the centre of the 7x7 grid.
    function automatic int tap_ring(input int t);
        int dy;
        int dx;
        dy = t / SPAN - RADIUS;
        dx = t % SPAN - RADIUS;
        if (dy < 0) dy = -dy;
        if (dx < 0) dx = -dx;
        return (dy > dx) ? dy : dx;
    endfunction
endpackage

// File: rtl/ifilt_linebuf.sv
module ifilt_linebuf
    import ifilt_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 12,
    parameter int SLOTS = 8,
    localparam int CW = $clog2(IMG_W),
    localparam int RW = $clog2(IMG_H),
    localparam int SW = $clog2(SLOTS)
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [RW-1:0]          wr_row,
    input  logic [CW-1:0]          wr_col,
    input  pix_t                   wr_data,
    input  logic [RW-1:0]          ctr_row,
    input  logic [CW-1:0]          ctr_col,
    output logic [TAPS-1:0][7:0]   taps
);
    timeunit 1ns;
    timeprecision 1ps;

    pix_t mem_q [SLOTS][IMG_W];
    logic [SW-1:0] wslot;

    assign wslot = SW'(int'(wr_row) % SLOTS);

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wslot][wr_col] <= wr_data;
        end
    end

    // Each tap reads the clamped (replicated-edge) position.
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        localparam int DY = t / SPAN - RADIUS;
        localparam int DX = t % SPAN - RADIUS;
        logic [SW-1:0] rs;
        logic [CW-1:0] cs;
        always_comb begin
            int rr;
            int cc;
            rr = int'(ctr_row) + DY;
            cc = int'(ctr_col) + DX;
            if (rr < 0) rr = 0;
            if (rr > IMG_H - 1) rr = IMG_H - 1;
            if (cc < 0) cc = 0;
            if (cc > IMG_W - 1) cc = IMG_W - 1;
            rs = SW'(rr % SLOTS);
            cs = CW'(cc);
            taps[t] = mem_q[rs][cs];
        end
    end
endmodule

// File: rtl/ifilt_window_select.sv
module ifilt_window_select
    import ifilt_pkg::*;
(
    input  logic [TAPS-1:0][7:0] win,
    output logic                 center_noisy,
    output logic [1:0]           sel_lvl,
    output logic [TAPS-1:0]      clean_mask,
    output logic [RANKW-1:0]     rank
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        int n1;
        int n2;
        int n3;
        int nsel;
        int area;
        int clean;
        n1 = 0;
        n2 = 0;
        n3 = 0;
        for (int t = 0; t < TAPS; t++) begin
            if (is_impulse(win[t])) begin
                if (tap_ring(t) <= 1) n1++;
                if (tap_ring(t) <= 2) n2++;
                n3++;
            end
        end
        // Smallest window whose damaged share is at most one half.
        if (2 * n1 <= 9) begin
            sel_lvl = 2'd1;
            nsel    = n1;
            area    = 9;
        end else if (2 * n2 <= 25) begin
            sel_lvl = 2'd2;
            nsel    = n2;
            area    = 25;
        end else if (2 * n3 <= TAPS) begin
            sel_lvl = 2'd3;
            nsel    = n3;
            area    = TAPS;
        end else begin
            sel_lvl = 2'd0;
            nsel    = n3;
            area    = n3;
        end
        clean = area - nsel;
        rank  = RANKW'((clean + 1) / 2);
        for (int t = 0; t < TAPS; t++) begin
            clean_mask[t] = !is_impulse(win[t]) && (sel_lvl != 2'd0)
                            && (tap_ring(t) <= int'(sel_lvl));
        end
        center_noisy = is_impulse(win[CENTER]);
    end
endmodule

// File: rtl/ifilt_rank_search.sv
module ifilt_rank_search
    import ifilt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [TAPS-1:0][7:0] win,
    input  logic [TAPS-1:0]      mask,
    input  logic [RANKW-1:0]     rank,
    output logic                 done,
    output pix_t                 value
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [2:0]       bitp;
        logic [RANKW-1:0] krem;
        pix_t             pref;
    } srch_t;

    srch_t q, d;

    // One result bit per cycle, most significant first: count masked
    // values that share the decided prefix and have a zero in this bit.
    always_comb begin
        pix_t             hm;
        int               c0;
        logic [RANKW-1:0] c0v;
        d  = q;
        hm = 8'hFF << ({1'b0, q.bitp} + 4'd1);
        c0 = 0;
        for (int t = 0; t < TAPS; t++) begin
            if (mask[t] && ((win[t] & hm) == (q.pref & hm)) && !win[t][q.bitp]) begin
                c0++;
            end
        end
        c0v    = RANKW'(c0);
        d.done = 1'b0;
        if (start) begin
            d.busy = 1'b1;
            d.bitp = 3'd7;
            d.krem = rank;
            d.pref = '0;
        end else if (q.busy) begin
            if (q.krem <= c0v) begin
                d.pref[q.bitp] = 1'b0;
            end else begin
                d.pref[q.bitp] = 1'b1;
                d.krem         = q.krem - c0v;
            end
            if (q.bitp == 3'd0) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.bitp = q.bitp - 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done  = q.done;
    assign value = q.pref;

    // R10: the result strobe lasts one cycle, so each pixel gets one result.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
endmodule

// File: rtl/impulse_adapt_filter.sv
module impulse_adapt_filter
    import ifilt_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 12,
    localparam int CW = $clog2(IMG_W),
    localparam int RW = $clog2(IMG_H),
    localparam int NPIX = IMG_W * IMG_H,
    localparam int NW = $clog2(NPIX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam pix_t PREV_INIT = 8'd128;
    localparam int   LOOKAHEAD = RADIUS + 1;

    typedef struct packed {
        eng_st_e              st;
        logic [RW-1:0]        in_row;
        logic [CW-1:0]        in_col;
        logic [NW-1:0]        in_cnt;
        logic [RW-1:0]        out_row;
        logic [CW-1:0]        out_col;
        pix_t                 prev;
        pix_t                 result;
        res_kind_e            kind;
        logic [TAPS-1:0][7:0] win;
    } ctl_t;

    ctl_t q, d;

    logic [TAPS-1:0][7:0] taps;
    logic                 center_noisy;
    logic [1:0]           sel_lvl;
    logic [TAPS-1:0]      clean_mask;
    logic [RANKW-1:0]     rank;
    logic                 srch_start;
    logic                 srch_done;
    pix_t                 srch_value;
    logic                 in_fire;
    logic                 out_fire;
    logic                 out_last;
    logic                 avail;

    ifilt_linebuf #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .SLOTS (8)
    ) i_lines (
        .clk     (clk),
        .wr_en   (in_fire),
        .wr_row  (q.in_row),
        .wr_col  (q.in_col),
        .wr_data (in_data),
        .ctr_row (q.out_row),
        .ctr_col (q.out_col),
        .taps    (taps)
    );

    ifilt_window_select i_select (
        .win          (q.win),
        .center_noisy (center_noisy),
        .sel_lvl      (sel_lvl),
        .clean_mask   (clean_mask),
        .rank         (rank)
    );

    ifilt_rank_search i_search (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srch_start),
        .win   (q.win),
        .mask  (clean_mask),
        .rank  (rank),
        .done  (srch_done),
        .value (srch_value)
    );

    // Input may run at most LOOKAHEAD rows ahead of the output row, so an
    // eight-row ring never overwrites a row that is still in use.
    always_comb begin
        int rr;
        int cc;
        rr = int'(q.out_row) + RADIUS;
        cc = int'(q.out_col) + RADIUS;
        if (rr > IMG_H - 1) rr = IMG_H - 1;
        if (cc > IMG_W - 1) cc = IMG_W - 1;
        avail    = int'(q.in_cnt) > (rr * IMG_W + cc);
        in_ready = (int'(q.in_cnt) < NPIX)
                   && (int'(q.in_row) <= int'(q.out_row) + LOOKAHEAD);
    end

    assign in_fire   = in_valid && in_ready;
    assign out_valid = (q.st == ST_EMIT);
    assign out_data  = q.result;
    assign out_fire  = out_valid && out_ready;
    assign out_last  = (int'(q.out_row) == IMG_H - 1) && (int'(q.out_col) == IMG_W - 1);

    always_comb begin
        d          = q;
        srch_start = 1'b0;
        if (in_fire) begin
            d.in_cnt = q.in_cnt + NW'(1);
            if (int'(q.in_col) == IMG_W - 1) begin
                d.in_col = '0;
                if (int'(q.in_row) != IMG_H - 1) d.in_row = q.in_row + RW'(1);
            end else begin
                d.in_col = q.in_col + CW'(1);
            end
        end
        case (q.st)
            ST_IDLE: begin
                if (avail) d.st = ST_LOAD;
            end
            ST_LOAD: begin
                d.win = taps;
                d.st  = ST_PREP;
            end
            ST_PREP: begin
                if (!center_noisy)          d.kind = RES_KEEP;
                else if (sel_lvl == 2'd0)   d.kind = RES_PREV;
                else                        d.kind = RES_MEDIAN;
                srch_start = 1'b1;
                d.st       = ST_SEARCH;
            end
            ST_SEARCH: begin
                if (srch_done) begin
                    case (q.kind)
                        RES_KEEP:   d.result = q.win[CENTER];
                        RES_PREV:   d.result = q.prev;
                        default:    d.result = srch_value;
                    endcase
                    d.st = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    d.st   = ST_IDLE;
                    d.prev = q.result;
                    if (out_last) begin
                        d.in_row  = '0;
                        d.in_col  = '0;
                        d.in_cnt  = '0;
                        d.out_row = '0;
                        d.out_col = '0;
                        d.prev    = PREV_INIT;
                    end else if (int'(q.out_col) == IMG_W - 1) begin
                        d.out_col = '0;
                        d.out_row = q.out_row + RW'(1);
                    end else begin
                        d.out_col = q.out_col + CW'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= RES_KEEP;
            q.prev <= PREV_INIT;
        end else begin
            q <= d;
        end
    end

    // R10: a stalled output keeps its pixel.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R1: a pass-through pixel never carries an impulse value.
    a_r1_keep_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && q.kind == RES_KEEP) |-> !is_impulse(out_data));

    // R7: a restored median comes from undamaged values only.
    a_r7_median_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && q.kind == RES_MEDIAN) |-> !is_impulse(out_data));

    // R3: the requested rank lies within the undamaged count of the chosen window.
    a_r3_rank_range: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PREP && sel_lvl != 2'd0)
            |-> (rank >= RANKW'(1) && int'(rank) <= $countones(clean_mask)));

    // R9: the carried value restarts at mid-grey once a frame is complete.
    a_r9_prev_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fire && out_last) |=> (q.prev == PREV_INIT));
endmodule

// File: tb/test_impulse_adapt_filter.sv
module test_impulse_adapt_filter;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W = 9;
    localparam int H = 7;
    localparam int NF = 6;
    localparam int NP = W * H;
    localparam int TOTAL = NF * NP;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;

    int img  [TOTAL];
    int expv [TOTAL];
    int expc [TOTAL];
    bit expb [TOTAL];
    bit expf [TOTAL];
    int checks = 0;
    int errors = 0;
    int in_idx = 0;
    int out_idx = 0;
    int cyc = 0;
    bit hold = 0;
    int holdv = 0;
    bit extra = 0;

    always #2.5 clk = ~clk;

    impulse_adapt_filter #(.IMG_W(W), .IMG_H(H)) i_impulse_adapt_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int ex);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, ex);
        end
    endtask

    function automatic logic [31:0] mix(input logic [31:0] x);
        logic [31:0] y;
        y = x * 32'h9E3779B1;
        y = y ^ (y >> 15);
        y = y * 32'h85EBCA77;
        y = y ^ (y >> 13);
        return y;
    endfunction

    function automatic bit bad(input int v);
        return (v == 0) || (v == 255);
    endfunction

    function automatic int clampi(input int v, input int hi);
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic int at(input int f, input int r, input int c);
        return img[f * NP + clampi(r, H - 1) * W + clampi(c, W - 1)];
    endfunction

    task automatic gen_frames();
        for (int f = 0; f < NF; f++) begin
            int dens;
            case (f)
                0: dens = 0;
                1: dens = 15;
                2: dens = 45;
                3: dens = 70;
                4: dens = 85;
                default: dens = 40;
            endcase
            for (int r = 0; r < H; r++) begin
                for (int c = 0; c < W; c++) begin
                    logic [31:0] h;
                    bit nz;
                    int v;
                    h  = mix(32'(f * NP + r * W + c) * 32'd7 + 32'(f) * 32'd977 + 32'd1);
                    nz = int'(h % 100) < dens;
                    if (f == 5 && r < 4 && c < 4) nz = 1'b1;
                    if (nz) v = h[8] ? 255 : 0;
                    else    v = 1 + int'((h >> 12) % 254);
                    if (f == 1 && r == 2 && c == 4) v = 1;
                    if (f == 1 && r == 4 && c == 2) v = 254;
                    img[f * NP + r * W + c] = v;
                end
            end
        end
    endtask

    // Arithmetic model of the requirements R1..R9.
    task automatic build_expected();
        for (int f = 0; f < NF; f++) begin
            int prev;
            prev = 128;
            for (int r = 0; r < H; r++) begin
                for (int c = 0; c < W; c++) begin
                    int idx;
                    int ctr;
                    int sel;
                    int res;
                    idx = f * NP + r * W + c;
                    ctr = img[idx];
                    expf[idx] = (r == 0 && c == 0);
                    expb[idx] = bad(ctr) && (r < 3 || c < 3 || r > H - 4 || c > W - 4);
                    if (!bad(ctr)) begin
                        res = ctr;
                        expc[idx] = 1;
                    end else begin
                        sel = 0;
                        for (int L = 1; L <= 3; L++) begin
                            int n;
                            n = 0;
                            for (int dy = -L; dy <= L; dy++)
                                for (int dx = -L; dx <= L; dx++)
                                    if (bad(at(f, r + dy, c + dx))) n++;
                            if (2 * n <= (2 * L + 1) * (2 * L + 1)) begin
                                sel = L;
                                break;
                            end
                        end
                        if (sel == 0) begin
                            res = prev;
                            expc[idx] = 5;
                        end else begin
                            int vals [49];
                            int m;
                            m = 0;
                            for (int dy = -sel; dy <= sel; dy++)
                                for (int dx = -sel; dx <= sel; dx++)
                                    if (!bad(at(f, r + dy, c + dx))) begin
                                        vals[m] = at(f, r + dy, c + dx);
                                        m++;
                                    end
                            for (int i = 1; i < m; i++) begin
                                int key;
                                int j;
                                key = vals[i];
                                j = i - 1;
                                while (j >= 0 && vals[j] > key) begin
                                    vals[j + 1] = vals[j];
                                    j--;
                                end
                                vals[j + 1] = key;
                            end
                            res = vals[(m + 1) / 2 - 1];
                            expc[idx] = sel + 1;
                        end
                    end
                    expv[idx] = res;
                    prev = res;
                end
            end
        end
    endtask

    initial begin
        gen_frames();
        build_expected();
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R11 reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R11 reset in_ready", int'(in_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R11 after reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R11 after reset in_ready", int'(in_ready), 1);
        while (out_idx < TOTAL && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            in_valid  = (in_idx < TOTAL) && ((cyc % 7) != 3);
            in_data   = in_valid ? 8'(img[in_idx]) : 8'h00;
            out_ready = ((cyc % 5) != 1) && ((cyc % 11) != 4);
            #1;
            if (hold) begin
                chk(out_valid && (int'(out_data) == holdv), "R10 stalled output held",
                    int'(out_data), holdv);
            end
            hold  = out_valid && !out_ready;
            holdv = int'(out_data);
            if (in_valid && in_ready) in_idx++;
            if (out_valid && out_ready) begin
                string tag;
                case (expc[out_idx])
                    1: tag = (img[out_idx] == 1 || img[out_idx] == 254) ? "R1/R2" : "R1";
                    2: tag = "R2/R3/R7";
                    3: tag = "R2/R4/R7";
                    4: tag = "R2/R5/R7";
                    default: tag = expf[out_idx] ? "R6/R9" : "R6";
                endcase
                if (expb[out_idx]) tag = {tag, "/R8"};
                tag = {tag, $sformatf(" pixel %0d", out_idx)};
                chk(int'(out_data) == expv[out_idx], tag, int'(out_data), expv[out_idx]);
                out_idx++;
            end
        end
        if (cyc >= LIMIT) begin
            chk(1'b0, "R10 watchdog expired, outputs", out_idx, TOTAL);
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (20) begin
            @(negedge clk);
            #1;
            if (out_valid) extra = 1'b1;
        end
        chk(!extra, "R10 no output beyond frame end", int'(extra), 0);
        chk(in_idx == TOTAL, "R10 all input pixels accepted", in_idx, TOTAL);
        chk(out_idx == TOTAL, "R10 output count", out_idx, TOTAL);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule